// File: doc/BRIEF.md
# Brewing Sequence Controller

This block runs one brewing cycle of a small appliance each time the start button is pressed. It watches a single start request and acts only on its rising edge, which it finds by comparing the request with its value from the previous clock. An accepted press clears the ready indicator and switches on the heater and the grinder. The grinder runs for a set number of clock cycles. One idle cycle follows, and then the pump runs for its own set number of cycles. The heater stays on through grinding, the idle cycle and pumping. It switches off together with the pump, and at that edge ready comes back.

One internal down-counter times both intervals. It is loaded with the interval length minus one when an interval begins, and it reports zero at the interval's last cycle, so each enable is high for exactly the configured number of cycles. At 1 MHz the defaults are one second of grinding and ten seconds of pumping, which fit in a 24-bit counter. A bench can set short intervals through the parameters. Every output is a register, so a decision made in one cycle appears on the pins at the following clock edge. A press made while a brew is running is dropped and is not stored for later.

Top module: `brewSequencer`

## Requirements
- R1: Only a 0-to-1 transition of `startReq` seen while idle starts a brew. A request held high, through the end of a brew or longer, never starts a second one.
- R2: At the clock edge after an accepted press, `readyOut` is 0 and `heaterEn` and `grinderEn` are both 1.
- R3: `grinderEn` stays high for exactly `GRIND_CYCLES` consecutive cycles.
- R4: After `grinderEn` falls, exactly one cycle passes with both `grinderEn` and `pumpEn` low before `pumpEn` rises. The two are never high in the same cycle.
- R5: `pumpEn` stays high for exactly `PUMP_CYCLES` consecutive cycles.
- R6: `pumpEn` and `heaterEn` fall at the same clock edge, and `readyOut` returns to 1 at that edge. `heaterEn` is high in every cycle from the first grinder cycle to the last pump cycle.
- R7: While `rst` (active high, synchronous) is applied, and in the cycle after it is released, `grinderEn`, `heaterEn` and `pumpEn` are 0 and `readyOut` is 1. This holds even when reset arrives in the middle of a brew.
- R8: A rising edge on `startReq` during any busy phase (grind, idle gap or pump, including its last cycle) has no effect and is not queued. The outputs follow the running brew and then stay idle.
- R9: After a brew completes, the controller waits again, and the next rising edge starts a complete new brew with the same timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 1 MHz nominal |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Start button level |
| grinderEn | output | 1 | Grinder enable |
| heaterEn | output | 1 | Heater enable |
| pumpEn | output | 1 | Pump enable |
| readyOut | output | 1 | High while idle and able to accept a press |

## Verification
A wrong phase or a wrong counter value shows up at the enable pins within one cycle. A grinder or pump pulse that is one cycle too short or too long, a missing or doubled dead cycle, or a heater that drops early is visible at the edge where it happens. A controller that stores a press made during a brew, or that takes a held-high request as a new one, gives a second pulse train only after the first brew ends. For this reason every scenario keeps checking the outputs for several idle cycles after the pump stops.

// File: rtl/brew_pkg.sv
package brew_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_GRIND = 2'd1,
    PH_GAP   = 2'd2,
    PH_PUMP  = 2'd3
  } brewPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadGrind;
    logic loadPump;
  } timerCmd_t;

endpackage

// File: rtl/brewDownTimer.sv
module brewDownTimer #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadEn,
  input  logic [WIDTH-1:0] loadVal,
  output logic             isZero
);

  logic [WIDTH-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (loadEn) begin
      count <= loadVal;
    end else if (count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign isZero = (count == '0);

  // a finished interval must not wrap round to the maximum value
  AST_TIMER_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (isZero && !loadEn) |=> isZero); // R3

  // a nonzero count steps down by one each cycle
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
    (!isZero && !loadEn) |=> (count == $past(count) - 1'b1)); // R5

endmodule

// File: rtl/brewDatapath.sv
module brewDatapath
  import brew_pkg::*;
#(
  parameter int TIMER_WIDTH  = 24,
  parameter int GRIND_CYCLES = 1000000,
  parameter int PUMP_CYCLES  = 10000000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      startReq,
  input  timerCmd_t cmd,
  output logic      startRise,
  output logic      timerZero
);

  localparam logic [TIMER_WIDTH-1:0] GRIND_LOAD = TIMER_WIDTH'(GRIND_CYCLES - 1);
  localparam logic [TIMER_WIDTH-1:0] PUMP_LOAD  = TIMER_WIDTH'(PUMP_CYCLES - 1);

  logic                   startPrev;
  logic                   loadEn;
  logic [TIMER_WIDTH-1:0] loadVal;

  // rising edge detector on the button level
  always_ff @(posedge clk) begin
    if (rst) begin
      startPrev <= 1'b0;
    end else begin
      startPrev <= startReq;
    end
  end

  assign startRise = startReq & ~startPrev;

  assign loadEn  = cmd.loadGrind | cmd.loadPump;
  assign loadVal = cmd.loadPump ? PUMP_LOAD : GRIND_LOAD;

  brewDownTimer #(
    .WIDTH(TIMER_WIDTH)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .loadEn (loadEn),
    .loadVal(loadVal),
    .isZero (timerZero)
  );

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
    !(cmd.loadGrind && cmd.loadPump)); // R4

  // a load starts a real interval: the timer is nonzero right after unless length is 1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    (cmd.loadPump && PUMP_CYCLES > 1) |=> !timerZero); // R5

endmodule

// File: rtl/brewControl.sv
module brewControl
  import brew_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      startRise,
  input  logic      timerZero,
  output timerCmd_t cmd,
  output logic      grinderEn,
  output logic      heaterEn,
  output logic      pumpEn,
  output logic      readyOut
);

  brewPhase_t phase;
  brewPhase_t nextPhase;

  always_comb begin
    nextPhase = phase;
    cmd       = '0;
    case (phase)
      PH_IDLE: begin
        if (startRise) begin
          nextPhase     = PH_GRIND;
          cmd.loadGrind = 1'b1;
        end
      end
      PH_GRIND: begin
        if (timerZero) nextPhase = PH_GAP;
      end
      PH_GAP: begin
        nextPhase    = PH_PUMP;
        cmd.loadPump = 1'b1;
      end
      PH_PUMP: begin
        if (timerZero) nextPhase = PH_IDLE;
      end
      default: nextPhase = PH_IDLE;
    endcase
  end

  // outputs registered from the phase being entered
  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      grinderEn <= 1'b0;
      heaterEn  <= 1'b0;
      pumpEn    <= 1'b0;
      readyOut  <= 1'b1;
    end else begin
      phase     <= nextPhase;
      grinderEn <= (nextPhase == PH_GRIND);
      heaterEn  <= (nextPhase != PH_IDLE);
      pumpEn    <= (nextPhase == PH_PUMP);
      readyOut  <= (nextPhase == PH_IDLE);
    end
  end

  AST_GRIND_PUMP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(grinderEn && pumpEn)); // R4

  AST_PUMP_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(pumpEn) |-> (!$past(grinderEn) && $past(grinderEn, 2))); // R4

  AST_HEAT_COVERS: assert property (@(posedge clk) disable iff (rst)
    (grinderEn || pumpEn) |-> heaterEn); // R6

  AST_PUMP_HEAT_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(pumpEn) |-> ($fell(heaterEn) && readyOut)); // R6

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
    readyOut |-> !heaterEn); // R2

  AST_START_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(grinderEn) |-> $past(startRise)); // R1

endmodule

// File: rtl/brewSequencer.sv
module brewSequencer #(
  parameter int TIMER_WIDTH  = 24,
  parameter int GRIND_CYCLES = 1000000,
  parameter int PUMP_CYCLES  = 10000000
) (
  input  logic clk,
  input  logic rst,
  input  logic startReq,
  output logic grinderEn,
  output logic heaterEn,
  output logic pumpEn,
  output logic readyOut
);

  import brew_pkg::*;

  timerCmd_t cmd;
  logic      startRise;
  logic      timerZero;

  brewDatapath #(
    .TIMER_WIDTH (TIMER_WIDTH),
    .GRIND_CYCLES(GRIND_CYCLES),
    .PUMP_CYCLES (PUMP_CYCLES)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .cmd      (cmd),
    .startRise(startRise),
    .timerZero(timerZero)
  );

  brewControl u_control (
    .clk      (clk),
    .rst      (rst),
    .startRise(startRise),
    .timerZero(timerZero),
    .cmd      (cmd),
    .grinderEn(grinderEn),
    .heaterEn (heaterEn),
    .pumpEn   (pumpEn),
    .readyOut (readyOut)
  );

endmodule

// File: tb/brewSequencer_bench.sv
module brewSequencer_bench;

  localparam int TW = 8;
  localparam int G  = 5;
  localparam int P  = 7;
  localparam int BUSY = G + P + 1;
  localparam int SPAN = BUSY + 3;
  localparam int NRUN = 6;
  // per run: cycles the press is held, and sample index of a second press (0 = none)
  localparam int HOLD  [NRUN] = '{1, 3, 20, 2, 1, 4};
  localparam int EXTRA [NRUN] = '{0, 6, 0, 9, 13, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startReq = 1'b0;
  logic grinderEn, heaterEn, pumpEn, readyOut;
  int   nRun = 0;
  int   nFail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  brewSequencer #(
    .TIMER_WIDTH (TW),
    .GRIND_CYCLES(G),
    .PUMP_CYCLES (P)
  ) u_brewSequencer (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .grinderEn(grinderEn),
    .heaterEn (heaterEn),
    .pumpEn   (pumpEn),
    .readyOut (readyOut)
  );

  // compares {grinder, heater, pump, ready}
  task automatic checkOut(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {grinderEn, heaterEn, pumpEn, readyOut};
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s at %0t: got g/h/p/r=%b expected %b", tag, $time, act, exp);
    end
  endtask

  function automatic logic [3:0] expAt(input int t);
    logic g, h, p;
    g = (t >= 1) && (t <= G);
    p = (t >= G + 2) && (t <= BUSY);
    h = (t >= 1) && (t <= BUSY);
    return {g, h, p, ~h};
  endfunction

  function automatic string tagAt(input int t, input bit again);
    if (t == 1) return again ? "R9" : "R2";
    if (t <= G) return "R3";
    if (t == G + 1) return "R4";
    if (t <= BUSY) return "R5";
    if (t == BUSY + 1) return "R6";
    return "R8";
  endfunction

  // called right after a negedge with startReq low
  task automatic runBrew(input int hold, input int extra, input bit again);
    startReq = 1'b1;
    for (int t = 1; t <= SPAN; t++) begin
      @(posedge clk);
      @(negedge clk);
      if (hold > SPAN && t > BUSY) checkOut("R1", expAt(t));
      else checkOut(tagAt(t, again), expAt(t));
      if (t == hold) startReq = 1'b0;
      if (extra != 0 && t == extra) startReq = 1'b1;
      if (extra != 0 && t == extra + 1) startReq = 1'b0;
    end
    startReq = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkOut("R1", 4'b0001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // reset state, during and just after reset
    repeat (3) @(negedge clk);
    checkOut("R7", 4'b0001);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkOut("R7", 4'b0001);
    repeat (2) @(negedge clk);
    checkOut("R7", 4'b0001);

    // table of press patterns
    for (int i = 0; i < NRUN; i++) begin
      runBrew(HOLD[i], EXTRA[i], i != 0);
    end

    // reset in the middle of the pump phase
    startReq = 1'b1;
    repeat (G + 4) begin
      @(posedge clk);
      @(negedge clk);
    end
    startReq = 1'b0;
    checkOut("R5", 4'b0110);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkOut("R7", 4'b0001);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkOut("R7", 4'b0001);
    repeat (BUSY) @(negedge clk);
    checkOut("R7", 4'b0001);

    // full brew after the reset
    runBrew(1, 0, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule